// File: doc/BRIEF.md
# I2C Memory Transaction Sequencer

This block sits on top of a bit-level I2C master engine and turns one request (probe, read or write) into the full ordered list of byte-level engine commands that a memory or register transaction needs. A request names a 7-bit device address, a memory address of zero to `MAX_ABYTES` bytes and a byte count. Write data is pulled from a valid/ready byte stream and read data is pushed out on another. When the transaction ends, the block pulses `done` and holds a status code and a count of data bytes the device refused.

The engine interface carries one command at a time: the block raises `eng_cmd_valid` with an opcode, a byte and an acknowledge bit, waits for `eng_cmd_ready`, then waits for exactly one `eng_rsp_valid` carrying the acknowledge result (and the received byte for reads) before it moves on. Bit timing, clock stretching and arbitration belong to the engine.

The address phase of a read is closed with a STOP and a fresh START, not a repeated START. In folding mode, memory-address bits above the transmitted address bytes are masked and merged into the device address, so a larger memory can answer as several 256-byte devices. A write keeps going when a data byte is refused and counts the refusals.

Top module: `i2c_mem_seq`

## Requirements
- R1: After reset `busy`, `done`, `eng_cmd_valid`, `wr_ready` and `rd_valid` are 0, `status` is 0 and `fail_cnt` is 0.
- R2: Engine commands use opcodes 0 = START, 1 = STOP, 2 = WRITE byte, 3 = READ byte. `eng_cmd_byte` is 0 for START, STOP and READ; `eng_cmd_ack` is 0 for all but READ. A command stays valid and unchanged until accepted, and no new command is raised before the response to the previous one.
- R3: A probe (`req_op` = 0 or 3) issues START, WRITE of {device, 0}, STOP; `status` is 1 if that byte is refused and 0 otherwise. Folding never applies to a probe.
- R4: A read (`req_op` = 1) with address length above zero issues START, WRITE {device, 0}, the address bytes most significant first, STOP, START, WRITE {device, 1}, the data reads, STOP.
- R5: A read with address length 0 issues START then WRITE {device, 1} directly, with no address-pointer phase.
- R6: The acknowledge result of the read-direction device byte is ignored: data bytes are still read and `status` ends at 0.
- R7: Every data READ carries `eng_cmd_ack` = 0 except the last, which carries 1; received bytes leave on the read stream in order.
- R8: If the write-direction device byte is refused (read or write), the block issues STOP and ends with `status` = 1.
- R9: If a memory-address byte is refused, the block issues STOP and ends with `status` = 2.
- R10: A write (`req_op` = 2) issues START, WRITE {device, 0}, the address bytes most significant first, one WRITE per data byte pulled from the write stream, STOP; a refused data byte does not stop the transfer and adds one to `fail_cnt`, and `status` is 0.
- R11: For reads and writes the device field sent is `req_dev | (fold_mask & ((req_maddr >> 8*alen) mod 128))`.
- R12: `done` is a one-cycle pulse after the final STOP is answered; `status` and `fail_cnt` keep their values until the next accepted request.
- R13: A `req_start` pulse while `busy` is 1 is ignored and does not alter the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Request pulse, taken when idle |
| req_op | input | 2 | 0/3 probe, 1 read, 2 write |
| req_dev | input | 7 | Device address |
| req_maddr | input | 8*MAX_ABYTES | Memory address |
| req_alen | input | clog2(MAX_ABYTES+1) | Memory-address length in bytes, clamped to MAX_ABYTES |
| req_len | input | LEN_W | Data byte count |
| fold_mask | input | 7 | Mask of high address bits merged into the device address |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | End-of-transaction pulse |
| status | output | 2 | 0 success, 1 device refused, 2 address refused |
| fail_cnt | output | LEN_W | Refused data bytes of the last write |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| eng_cmd_valid | output | 1 | Engine command valid |
| eng_cmd_ready | input | 1 | Engine takes command |
| eng_cmd_op | output | 2 | Engine opcode |
| eng_cmd_ack | output | 1 | Acknowledge level to send after a READ |
| eng_cmd_byte | output | 8 | Byte for WRITE |
| eng_rsp_valid | input | 1 | Engine result pulse |
| eng_rsp_nack | input | 1 | Byte refused by the device |
| eng_rsp_byte | input | 8 | Byte received for READ |

## Verification
The properties assume an engine that answers each accepted command with exactly one response pulse, never answers unprompted, and never answers in the cycle it accepts. The bench engine model grants `eng_cmd_ready` on an irregular pattern, replies one cycle after acceptance and only then, so that assumption holds in every sweep point. Refusals are injected per command index from a table the bench builds alongside the expected command list, which keeps the model independent of the design's step order.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [1:0] {
        ENG_START = 2'd0,
        ENG_STOP  = 2'd1,
        ENG_WRITE = 2'd2,
        ENG_READ  = 2'd3
    } eng_op_e;

    typedef enum logic [1:0] {
        XFER_PROBE = 2'd0,
        XFER_READ  = 2'd1,
        XFER_WRITE = 2'd2
    } xfer_e;

    typedef enum logic [1:0] {
        RES_OK        = 2'd0,
        RES_DEV_NACK  = 2'd1,
        RES_ADDR_NACK = 2'd2
    } res_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ISSUE,
        PH_WAIT,
        PH_WFETCH,
        PH_RPUSH
    } phase_e;

    typedef enum logic [3:0] {
        SP_START1,
        SP_DEVW,
        SP_MADDR,
        SP_MSTOP,
        SP_START2,
        SP_DEVR,
        SP_RDATA,
        SP_WDATA,
        SP_STOP
    } step_e;

    typedef struct packed {
        eng_op_e    op;
        logic       ack;
        logic [7:0] data;
    } eng_cmd_t;

    function automatic xfer_e decode_op(input logic [1:0] code);
        case (code)
            2'd1:    return XFER_READ;
            2'd2:    return XFER_WRITE;
            default: return XFER_PROBE;
        endcase
    endfunction

    function automatic logic [7:0] dev_frame(input logic [6:0] dev, input logic rnw);
        return {dev, rnw};
    endfunction

endpackage

// File: rtl/i2cseq_fold.sv
module i2cseq_fold
    import i2cseq_pkg::*;
#(
    parameter int MAX_ABYTES = 4,
    localparam int AL_W      = $clog2(MAX_ABYTES + 1),
    localparam int MADDR_W   = 8 * MAX_ABYTES
) (
    input  xfer_e              op,
    input  logic [6:0]         dev,
    input  logic [MADDR_W-1:0] maddr,
    input  logic [AL_W-1:0]    alen_raw,
    input  logic [6:0]         mask,
    output logic [6:0]         dev_eff,
    output logic [AL_W-1:0]    alen_eff
);

    always_comb begin
        if (alen_raw > AL_W'(MAX_ABYTES)) alen_eff = AL_W'(MAX_ABYTES);
        else                              alen_eff = alen_raw;
    end

    always_comb begin
        if (op == XFER_PROBE)
            dev_eff = dev;
        else
            dev_eff = dev | (7'({8'h00, maddr} >> {alen_eff, 3'b000}) & mask);
    end

endmodule

// File: rtl/i2cseq_fail_ctr.sv
module i2cseq_fail_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (inc)    cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
    import i2cseq_pkg::*;
#(
    parameter int LEN_W      = 8,
    parameter int MAX_ABYTES = 4,
    localparam int AL_W      = $clog2(MAX_ABYTES + 1),
    localparam int MADDR_W   = 8 * MAX_ABYTES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_start,
    input  xfer_e              req_op,
    input  logic [6:0]         dev_eff,
    input  logic [MADDR_W-1:0] req_maddr,
    input  logic [AL_W-1:0]    alen_eff,
    input  logic [LEN_W-1:0]   req_len,
    output logic               busy,
    output logic               done,
    output res_e               status,
    input  logic               wr_valid,
    output logic               wr_ready,
    input  logic [7:0]         wr_data,
    output logic               rd_valid,
    input  logic               rd_ready,
    output logic [7:0]         rd_data,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output eng_cmd_t           cmd,
    input  logic               rsp_valid,
    input  logic               rsp_nack,
    input  logic [7:0]         rsp_byte,
    output logic               fail_clr,
    output logic               fail_inc
);

    phase_e             phase_q;
    step_e              step_q;
    xfer_e              op_q;
    logic [6:0]         dev_q;
    logic [MADDR_W-1:0] maddr_q;
    logic [AL_W-1:0]    alen_q;
    logic [AL_W-1:0]    idx_q;
    logic [LEN_W-1:0]   len_q;
    logic [7:0]         byte_q;
    res_e               status_q;
    logic               done_q;
    logic               last_byte;
    logic               rsp_take;

    assign last_byte = (len_q == LEN_W'(1));
    assign rsp_take  = (phase_q == PH_WAIT) && rsp_valid;

    // Command word follows the current step.
    always_comb begin
        cmd.op   = ENG_START;
        cmd.ack  = 1'b0;
        cmd.data = 8'h00;
        case (step_q)
            SP_START1, SP_START2: cmd.op = ENG_START;
            SP_MSTOP, SP_STOP:    cmd.op = ENG_STOP;
            SP_DEVW: begin
                cmd.op   = ENG_WRITE;
                cmd.data = dev_frame(dev_q, 1'b0);
            end
            SP_DEVR: begin
                cmd.op   = ENG_WRITE;
                cmd.data = dev_frame(dev_q, 1'b1);
            end
            SP_MADDR: begin
                cmd.op   = ENG_WRITE;
                cmd.data = 8'(maddr_q >> {idx_q, 3'b000});
            end
            SP_WDATA: begin
                cmd.op   = ENG_WRITE;
                cmd.data = byte_q;
            end
            SP_RDATA: begin
                cmd.op  = ENG_READ;
                cmd.ack = last_byte;
            end
            default: cmd.op = ENG_START;
        endcase
    end

    assign cmd_valid = (phase_q == PH_ISSUE);
    assign wr_ready  = (phase_q == PH_WFETCH);
    assign rd_valid  = (phase_q == PH_RPUSH);
    assign rd_data   = byte_q;
    assign busy      = (phase_q != PH_IDLE);
    assign done      = done_q;
    assign status    = status_q;
    assign fail_clr  = (phase_q == PH_IDLE) && req_start;
    assign fail_inc  = rsp_take && (step_q == SP_WDATA) && rsp_nack;

    always_ff @(posedge clk) begin
        done_q <= 1'b0;
        if (rst) begin
            phase_q  <= PH_IDLE;
            step_q   <= SP_START1;
            op_q     <= XFER_PROBE;
            dev_q    <= '0;
            maddr_q  <= '0;
            alen_q   <= '0;
            idx_q    <= '0;
            len_q    <= '0;
            byte_q   <= '0;
            status_q <= RES_OK;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (req_start) begin
                        op_q     <= req_op;
                        dev_q    <= dev_eff;
                        maddr_q  <= req_maddr;
                        alen_q   <= alen_eff;
                        len_q    <= req_len;
                        status_q <= RES_OK;
                        step_q   <= SP_START1;
                        phase_q  <= PH_ISSUE;
                    end
                end
                PH_ISSUE: begin
                    if (cmd_ready) phase_q <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (rsp_valid) begin
                        phase_q <= PH_ISSUE;
                        case (step_q)
                            SP_START1: begin
                                if (op_q == XFER_READ && alen_q == '0) step_q <= SP_DEVR;
                                else                                   step_q <= SP_DEVW;
                            end
                            SP_DEVW: begin
                                if (rsp_nack) begin
                                    status_q <= RES_DEV_NACK;
                                    step_q   <= SP_STOP;
                                end else if (op_q == XFER_PROBE) begin
                                    step_q <= SP_STOP;
                                end else if (alen_q != '0) begin
                                    idx_q  <= alen_q - AL_W'(1);
                                    step_q <= SP_MADDR;
                                end else if (len_q == '0) begin
                                    step_q <= SP_STOP;
                                end else begin
                                    step_q  <= SP_WDATA;
                                    phase_q <= PH_WFETCH;
                                end
                            end
                            SP_MADDR: begin
                                if (rsp_nack) begin
                                    status_q <= RES_ADDR_NACK;
                                    step_q   <= SP_STOP;
                                end else if (idx_q != '0) begin
                                    idx_q <= idx_q - AL_W'(1);
                                end else if (op_q == XFER_READ) begin
                                    step_q <= SP_MSTOP;
                                end else if (len_q == '0) begin
                                    step_q <= SP_STOP;
                                end else begin
                                    step_q  <= SP_WDATA;
                                    phase_q <= PH_WFETCH;
                                end
                            end
                            SP_MSTOP:  step_q <= SP_START2;
                            SP_START2: step_q <= SP_DEVR;
                            SP_DEVR: begin
                                if (len_q == '0) step_q <= SP_STOP;
                                else             step_q <= SP_RDATA;
                            end
                            SP_RDATA: begin
                                byte_q  <= rsp_byte;
                                phase_q <= PH_RPUSH;
                            end
                            SP_WDATA: begin
                                len_q <= len_q - LEN_W'(1);
                                if (last_byte) step_q  <= SP_STOP;
                                else           phase_q <= PH_WFETCH;
                            end
                            SP_STOP: begin
                                phase_q <= PH_IDLE;
                                done_q  <= 1'b1;
                            end
                            default: step_q <= SP_STOP;
                        endcase
                    end
                end
                PH_WFETCH: begin
                    if (wr_valid) begin
                        byte_q  <= wr_data;
                        phase_q <= PH_ISSUE;
                    end
                end
                PH_RPUSH: begin
                    if (rd_ready) begin
                        len_q   <= len_q - LEN_W'(1);
                        phase_q <= PH_ISSUE;
                        step_q  <= last_byte ? SP_STOP : SP_RDATA;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2c_mem_seq.sv
module i2c_mem_seq
    import i2cseq_pkg::*;
#(
    parameter int LEN_W      = 8,
    parameter int MAX_ABYTES = 4,
    localparam int AL_W      = $clog2(MAX_ABYTES + 1),
    localparam int MADDR_W   = 8 * MAX_ABYTES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_start,
    input  logic [1:0]         req_op,
    input  logic [6:0]         req_dev,
    input  logic [MADDR_W-1:0] req_maddr,
    input  logic [AL_W-1:0]    req_alen,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [6:0]         fold_mask,
    output logic               busy,
    output logic               done,
    output logic [1:0]         status,
    output logic [LEN_W-1:0]   fail_cnt,
    input  logic               wr_valid,
    output logic               wr_ready,
    input  logic [7:0]         wr_data,
    output logic               rd_valid,
    input  logic               rd_ready,
    output logic [7:0]         rd_data,
    output logic               eng_cmd_valid,
    input  logic               eng_cmd_ready,
    output logic [1:0]         eng_cmd_op,
    output logic               eng_cmd_ack,
    output logic [7:0]         eng_cmd_byte,
    input  logic               eng_rsp_valid,
    input  logic               eng_rsp_nack,
    input  logic [7:0]         eng_rsp_byte
);

    xfer_e           op_dec;
    logic [6:0]      dev_eff;
    logic [AL_W-1:0] alen_eff;
    res_e            status_e;
    eng_cmd_t        cmd;
    logic            fail_clr;
    logic            fail_inc;

    assign op_dec = decode_op(req_op);

    i2cseq_fold #(.MAX_ABYTES(MAX_ABYTES)) u_fold (
        .op       (op_dec),
        .dev      (req_dev),
        .maddr    (req_maddr),
        .alen_raw (req_alen),
        .mask     (fold_mask),
        .dev_eff  (dev_eff),
        .alen_eff (alen_eff)
    );

    i2cseq_ctrl #(.LEN_W(LEN_W), .MAX_ABYTES(MAX_ABYTES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_start (req_start),
        .req_op    (op_dec),
        .dev_eff   (dev_eff),
        .req_maddr (req_maddr),
        .alen_eff  (alen_eff),
        .req_len   (req_len),
        .busy      (busy),
        .done      (done),
        .status    (status_e),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_data   (wr_data),
        .rd_valid  (rd_valid),
        .rd_ready  (rd_ready),
        .rd_data   (rd_data),
        .cmd_valid (eng_cmd_valid),
        .cmd_ready (eng_cmd_ready),
        .cmd       (cmd),
        .rsp_valid (eng_rsp_valid),
        .rsp_nack  (eng_rsp_nack),
        .rsp_byte  (eng_rsp_byte),
        .fail_clr  (fail_clr),
        .fail_inc  (fail_inc)
    );

    i2cseq_fail_ctr #(.W(LEN_W)) u_fail (
        .clk (clk),
        .rst (rst),
        .clr (fail_clr),
        .inc (fail_inc),
        .cnt (fail_cnt)
    );

    assign status       = status_e;
    assign eng_cmd_op   = cmd.op;
    assign eng_cmd_ack  = cmd.ack;
    assign eng_cmd_byte = cmd.data;

endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_start,
    input logic             busy,
    input logic             done,
    input logic [1:0]       status,
    input logic [LEN_W-1:0] fail_cnt,
    input logic             wr_ready,
    input logic             rd_valid,
    input logic             eng_cmd_valid,
    input logic             eng_cmd_ready,
    input logic [1:0]       eng_cmd_op,
    input logic             eng_cmd_ack,
    input logic [7:0]       eng_cmd_byte,
    input logic             eng_rsp_valid,
    input logic             eng_rsp_nack
);

    // R2: a pending command is held unchanged until the engine takes it
    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (rst)
        eng_cmd_valid && !eng_cmd_ready |=>
            eng_cmd_valid && $stable(eng_cmd_op) && $stable(eng_cmd_byte) && $stable(eng_cmd_ack));

    // R2: only one of command, write pull and read push is active
    p_one_channel_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eng_cmd_valid, wr_ready, rd_valid}));

    // R12: done only when the block has gone idle after a STOP answer
    p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(eng_rsp_valid) && eng_cmd_op == 2'd1);

    // R12: results are held while idle and no request arrives
    p_hold_result_r12: assert property (@(posedge clk) disable iff (rst)
        !busy && !req_start |=> $stable(status) && $stable(fail_cnt));

    // R10: the refusal count moves only after a refused WRITE
    p_fail_step_r10: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && fail_cnt != $past(fail_cnt) |->
            $past(eng_rsp_valid && eng_rsp_nack && eng_cmd_op == 2'd2));

    // R1: outputs quiet after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !busy && !done && status == 2'd0 && fail_cnt == '0);

endmodule

bind i2c_mem_seq i2cseq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_start     (req_start),
    .busy          (busy),
    .done          (done),
    .status        (status),
    .fail_cnt      (fail_cnt),
    .wr_ready      (wr_ready),
    .rd_valid      (rd_valid),
    .eng_cmd_valid (eng_cmd_valid),
    .eng_cmd_ready (eng_cmd_ready),
    .eng_cmd_op    (eng_cmd_op),
    .eng_cmd_ack   (eng_cmd_ack),
    .eng_cmd_byte  (eng_cmd_byte),
    .eng_rsp_valid (eng_rsp_valid),
    .eng_rsp_nack  (eng_rsp_nack)
);

// File: tb/tb_i2c_mem_seq.sv
module tb_i2c_mem_seq;

    localparam int LEN_W   = 8;
    localparam int MAXA    = 4;
    localparam int AL_W    = $clog2(MAXA + 1);
    localparam int MADDR_W = 8 * MAXA;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic               req_start = 1'b0;
    logic [1:0]         req_op = '0;
    logic [6:0]         req_dev = '0;
    logic [MADDR_W-1:0] req_maddr = '0;
    logic [AL_W-1:0]    req_alen = '0;
    logic [LEN_W-1:0]   req_len = '0;
    logic [6:0]         fold_mask = '0;
    logic               busy, done;
    logic [1:0]         status;
    logic [LEN_W-1:0]   fail_cnt;
    logic               wr_valid = 1'b1;
    logic               wr_ready;
    logic [7:0]         wr_data = '0;
    logic               rd_valid;
    logic               rd_ready = 1'b1;
    logic [7:0]         rd_data;
    logic               eng_cmd_valid;
    logic               eng_cmd_ready = 1'b0;
    logic [1:0]         eng_cmd_op;
    logic               eng_cmd_ack;
    logic [7:0]         eng_cmd_byte;
    logic               eng_rsp_valid = 1'b0;
    logic               eng_rsp_nack = 1'b0;
    logic [7:0]         eng_rsp_byte = '0;

    i2c_mem_seq #(.LEN_W(LEN_W), .MAX_ABYTES(MAXA)) dut (.*);

    int nvec = 0, nerr = 0;
    logic [10:0] exp_cmd [32];
    bit          exp_nack[32];
    int          exp_n;
    logic [10:0] got_cmd [32];
    int          got_n = 0;
    logic [7:0]  exp_rd [8];
    int          exp_rdn;
    logic [7:0]  rd_got [8];
    int          rd_n = 0;
    int          wptr = 0;
    int          txn = 0;
    int          hold_err = 0, proto_err = 0;

    function automatic logic [7:0] rb(input int k);
        return 8'hC3 ^ 8'(k * 29);
    endfunction

    function automatic logic [7:0] wb(input int j);
        return 8'h5A ^ 8'(txn * 7 + j * 19);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Engine model, driven away from the active edge
    bit          pending = 0, hold = 0;
    int          pend_idx = 0;
    logic [10:0] hold_cmd = '0;
    int          tick = 0;
    always @(negedge clk) begin
        if (rst) begin
            eng_rsp_valid = 1'b0;
            pending = 0;
            hold = 0;
        end else begin
            if (hold && (!eng_cmd_valid || {eng_cmd_op, eng_cmd_ack, eng_cmd_byte} != hold_cmd))
                hold_err++;
            hold = 0;
            eng_rsp_valid = 1'b0;
            if (pending) begin
                if (eng_cmd_valid) proto_err++;
                eng_rsp_valid = 1'b1;
                eng_rsp_nack  = (pend_idx < exp_n && pend_idx < 32) ? exp_nack[pend_idx] : 1'b0;
                eng_rsp_byte  = rb(pend_idx);
                pending = 0;
            end else if (eng_cmd_valid) begin
                eng_cmd_ready = (tick % 3 != 1);
                tick++;
                if (eng_cmd_ready) begin
                    if (got_n < 32) got_cmd[got_n] = {eng_cmd_op, eng_cmd_ack, eng_cmd_byte};
                    pend_idx = got_n;
                    got_n++;
                    pending = 1;
                end else begin
                    hold = 1;
                    hold_cmd = {eng_cmd_op, eng_cmd_ack, eng_cmd_byte};
                end
            end
            if (wr_ready) begin
                wr_data = wb(wptr);
                wptr++;
            end
            if (rd_valid) begin
                if (rd_n < 8) rd_got[rd_n] = rd_data;
                rd_n++;
            end
        end
    end

    task automatic push(input logic [1:0] op, input logic ack, input logic [7:0] b, input bit nk);
        if (exp_n < 32) begin
            exp_cmd[exp_n]  = {op, ack, b};
            exp_nack[exp_n] = nk;
        end
        exp_n++;
    endtask

    task automatic run_txn(input int op, input logic [6:0] dev, input logic [31:0] maddr,
                           input int alen, input int len, input logic [6:0] mask,
                           input int sc, input bit inject);
        logic [6:0] dv;
        int e_stat, e_fail, e_wr, n;
        bit do_read, abort;
        string ctag, stag;
        dv = dev;
        if (op != 0) dv = dev | (7'({8'h00, maddr} >> (8 * alen)) & mask);
        exp_n = 0; exp_rdn = 0; e_stat = 0; e_fail = 0; e_wr = 0;
        do_read = 0; abort = 0;
        push(2'd0, 1'b0, 8'h00, 1'b0);
        if (op == 0) begin
            push(2'd2, 1'b0, {dev, 1'b0}, sc == 1);
            push(2'd1, 1'b0, 8'h00, 1'b0);
            e_stat = (sc == 1) ? 1 : 0;
        end else if (op == 2 || alen > 0) begin
            push(2'd2, 1'b0, {dv, 1'b0}, sc == 1);
            if (sc == 1) begin
                push(2'd1, 1'b0, 8'h00, 1'b0);
                e_stat = 1;
            end else begin
                for (int k = alen - 1; k >= 0; k--) begin
                    push(2'd2, 1'b0, 8'(maddr >> (8 * k)), sc == 2 && k == 0);
                    if (sc == 2 && k == 0) begin
                        push(2'd1, 1'b0, 8'h00, 1'b0);
                        e_stat = 2;
                        abort = 1;
                    end
                end
                if (!abort) begin
                    if (op == 1) begin
                        push(2'd1, 1'b0, 8'h00, 1'b0);
                        push(2'd0, 1'b0, 8'h00, 1'b0);
                        do_read = 1;
                    end else begin
                        for (int j = 0; j < len; j++) begin
                            push(2'd2, 1'b0, wb(j), sc == 3 && j % 2 == 0);
                            if (sc == 3 && j % 2 == 0) e_fail++;
                            e_wr++;
                        end
                        push(2'd1, 1'b0, 8'h00, 1'b0);
                    end
                end
            end
        end else begin
            do_read = 1;
        end
        if (do_read) begin
            push(2'd2, 1'b0, {dv, 1'b1}, sc == 3 || (sc == 1 && alen == 0));
            for (int j = 0; j < len; j++) begin
                exp_rd[exp_rdn] = rb(exp_n);
                exp_rdn++;
                push(2'd3, (j == len - 1), 8'h00, 1'b0);
            end
            push(2'd1, 1'b0, 8'h00, 1'b0);
        end

        if (op == 0)                       ctag = "R3";
        else if (op == 2)                  ctag = "R10";
        else if (alen > 0)                 ctag = "R4 R7";
        else                               ctag = "R5 R7";
        if (mask != 0)                     ctag = {ctag, " R11"};
        if (inject)                        ctag = {ctag, " R13"};
        if (op == 0)                       stag = "R3";
        else if (e_stat == 1)              stag = "R8";
        else if (e_stat == 2)              stag = "R9";
        else if (op == 1 && (sc == 3 || (sc == 1 && alen == 0))) stag = "R6";
        else                               stag = "R12";

        got_n = 0; rd_n = 0; wptr = 0;
        @(negedge clk);
        req_op = 2'(op); req_dev = dev; req_maddr = maddr; req_alen = AL_W'(alen);
        req_len = LEN_W'(len); fold_mask = mask; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
            if (inject && n == 6) begin
                req_op = 2'd0; req_dev = 7'h11; req_start = 1'b1;
            end else begin
                req_start = 1'b0;
            end
        end
        req_start = 1'b0;
        chk(done, "R12", "done seen", 32'(done), 1);
        chk(status == 2'(e_stat), stag, "status", 32'(status), 32'(e_stat));
        chk(fail_cnt == LEN_W'(e_fail), "R10", "fail count", 32'(fail_cnt), 32'(e_fail));
        chk(got_n == exp_n, ctag, "command count", 32'(got_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < got_n && i < 32; i++)
            chk(got_cmd[i] == exp_cmd[i], ctag, $sformatf("command %0d", i),
                32'(got_cmd[i]), 32'(exp_cmd[i]));
        chk(rd_n == exp_rdn, "R7", "read byte count", 32'(rd_n), 32'(exp_rdn));
        for (int i = 0; i < exp_rdn && i < rd_n; i++)
            chk(rd_got[i] == exp_rd[i], "R7", $sformatf("read byte %0d", i),
                32'(rd_got[i]), 32'(exp_rd[i]));
        chk(wptr == e_wr, "R10", "write bytes pulled", 32'(wptr), 32'(e_wr));
        @(negedge clk);
        chk(!done && !busy, "R12", "done single pulse", 32'({done, busy}), 0);
        repeat (2) @(negedge clk);
        chk(status == 2'(e_stat) && fail_cnt == LEN_W'(e_fail), "R12", "result held",
            32'({status, fail_cnt}), 32'({2'(e_stat), LEN_W'(e_fail)}));
        txn++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R12 watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !eng_cmd_valid && !wr_ready && !rd_valid, "R1", "idle flags",
            32'({busy, done, eng_cmd_valid, wr_ready, rd_valid}), 0);
        chk(status == 2'd0 && fail_cnt == '0, "R1", "reset result",
            32'({status, fail_cnt}), 0);
        for (int op = 0; op < 3; op++)
            for (int alen = 0; alen <= MAXA; alen++)
                for (int len = 0; len < 4; len++)
                    for (int sc = 0; sc < 4; sc++) begin
                        if (op == 0 && len != 0) continue;
                        run_txn(op, 7'h48 ^ 7'(txn * 5), 32'h8E6B_D247 ^ 32'(txn * 32'h0101_0101),
                                alen, len, ((alen + len) % 2 == 1) ? 7'h0B : 7'h00, sc, 1'b0);
                    end
        run_txn(2, 7'h2C, 32'h0000_A1B2, 2, 3, 7'h00, 3, 1'b1);
        chk(hold_err == 0, "R2", "command held until taken", 32'(hold_err), 0);
        chk(proto_err == 0, "R2", "no command before response", 32'(proto_err), 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule